// File: doc/BRIEF.md
# Multi-Bank Configurable Interrupt Controller

This block gathers interrupt sources from across the chip and presents them to a processor. The sources are grouped into banks of 32. Each source has two control bits, polarity and edge. Together they choose the trigger mode: active-high level, active-low level, rising edge or falling edge. Every raw input passes through a two-flop synchroniser before it is used.

Each bank has six word registers, reached through a simple single-cycle register port:

- latched status
- enable mask
- write-one-to-set
- write-one-to-clear
- polarity
- edge select

A source is pending when its status bit and its enable bit are both 1. Each bank drives its own request line, which is high while anything in that bank is pending. Each bank also gives the index of its lowest-numbered pending source, so the handler can go straight to the right source.

Edge-mode sources latch into status and stay there until software clears them. Level-mode sources show their polarity-adjusted input directly in status. A bit forced by a write to the set register is held as a latched bit in either mode.

Top module: `intc_multibank`

## Requirements
- R1: Bank b starts at byte address b*0x18. Register offsets within a bank are 0x0 status, 0x4 enable, 0x8 set, 0xC clear, 0x10 polarity and 0x14 edge. Enable, polarity and edge read back the value last written. Set and clear always read 0. Writes to status are ignored. Any address beyond the last bank reads 0.
- R2: After reset, all enable, polarity, edge and latched status bits are 0, and every request line is low.
- R3: A bank's request line is high exactly when (status AND enable) is non-zero. Banks are independent: activity in one bank never affects the request or index of another.
- R4: A bank's index output equals the position of the lowest-numbered bit that is set in (status AND enable).
- R5: With polarity 1 and edge 0 (active-high level), the status bit is 1 while the input is high. It becomes visible after the second rising clock edge following the input change. A clear has no lasting effect while the input stays high.
- R6: With polarity 0 and edge 0 (active-low level), the status bit is 1 while the input is low.
- R7: With polarity 1 and edge 1 (rising edge), a low-to-high input latches the status bit. It appears after the third rising clock edge, one cycle after the synchronised transition. A high-to-low input latches nothing. The bit stays at 1 after the input returns low.
- R8: With polarity 0 and edge 1 (falling edge), a high-to-low input latches the status bit, with the same timing as R7. A low-to-high input latches nothing.
- R9: Writing 1 to a bit of the clear register clears that latched status bit on the next clock. Writing 0 leaves the bit unchanged. A clear wins over an edge event on the same bit in the same cycle.
- R10: Writing 1 to a bit of the set register sets that latched status bit on the next clock, in any trigger mode. The bit holds until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*32 | Raw interrupt inputs; bank b uses bits [b*32 +: 32] |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe; the write takes effect on the next clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_BANKS | Per-bank request line |
| irq_idx_o | output | NUM_BANKS*5 | Per-bank lowest pending source index, 5 bits per bank |

## Verification
The bench checks the exact latency of each trigger mode:

- Level status must appear after the second edge and not after the first.
- Edge status must appear after the third edge and not after the second.

An off-by-one synchroniser or edge detector would fail one of these timing checks.

For edge modes, the bench drives the opposite transition and expects nothing to latch. A design that detected edges by XOR would latch on it. For level-high mode, the bench clears a bit while the input is still asserted and expects the status to stay at 1. A design that let clears stick in level mode would drop a live interrupt.

For priority, several sources are forced pending through the set register and the lowest ones are masked off. The index must track the lowest enabled pending bit as bits are cleared one by one. Finally, the bench checks the ignored status write, the zero readback of set and clear, and the zero readback of an address past the last bank.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int REG_COUNT  = 6;
    localparam int BANK_BYTES = REG_COUNT * 4;

    typedef enum logic [2:0] {
        RS_STAT = 3'd0,
        RS_EN   = 3'd1,
        RS_SET  = 3'd2,
        RS_CLR  = 3'd3,
        RS_POL  = 3'd4,
        RS_EDGE = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/intc_sync2.sv
module intc_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] raw_i,
    input  logic             wr_i,
    input  logic [2:0]       sel_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] rdata_o,
    output logic [SRC_W-1:0] pend_o
);
    logic [SRC_W-1:0] sync_w, prev_q;
    logic [SRC_W-1:0] en_q, pol_q, edg_q, lat_q;
    logic [SRC_W-1:0] set_w, clr_w, evt_w, lvl_w, status_w;

    intc_sync2 #(.W(SRC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_i),
        .q_o  (sync_w)
    );

    always_comb begin
        set_w    = (wr_i && sel_i == RS_SET) ? wdata_i : '0;
        clr_w    = (wr_i && sel_i == RS_CLR) ? wdata_i : '0;
        evt_w    = edg_q & ((pol_q & sync_w & ~prev_q) | (~pol_q & ~sync_w & prev_q));
        lvl_w    = ~(sync_w ^ pol_q);
        status_w = lat_q | (~edg_q & lvl_w);
        pend_o   = status_w & en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            en_q   <= '0;
            pol_q  <= '0;
            edg_q  <= '0;
            lat_q  <= '0;
        end else begin
            prev_q <= sync_w;
            lat_q  <= (lat_q | evt_w | set_w) & ~clr_w;
            if (wr_i && sel_i == RS_EN)   en_q  <= wdata_i;
            if (wr_i && sel_i == RS_POL)  pol_q <= wdata_i;
            if (wr_i && sel_i == RS_EDGE) edg_q <= wdata_i;
        end
    end

    always_comb begin
        unique case (sel_i)
            RS_STAT: rdata_o = status_w;
            RS_EN:   rdata_o = en_q;
            RS_POL:  rdata_o = pol_q;
            RS_EDGE: rdata_o = edg_q;
            default: rdata_o = '0;
        endcase
    end

    // R9: a cleared bit is 0 on the following cycle
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w != '0) |=> ((lat_q & $past(clr_w)) == '0));

    // R10: a set bit (not cleared at the same time) is held on the next cycle
    a_r10_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_w & ~clr_w) != '0) |=> (($past(set_w & ~clr_w) & ~lat_q) == '0));

    // R7: a latched bit only appears after an edge event or a set write
    a_r7_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(evt_w | set_w)) == '0));
endmodule

// File: rtl/intc_multibank.sv
module intc_multibank
    import intc_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = $clog2(SRC_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*SRC_W-1:0] src_i,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [SRC_W-1:0]           bus_wdata,
    output logic [SRC_W-1:0]           bus_rdata,
    output logic [NUM_BANKS-1:0]       irq_o,
    output logic [NUM_BANKS*IDX_W-1:0] irq_idx_o
);
    logic [ADDR_W-1:0] bsel_w;
    logic [4:0]        boff_w;
    logic              aligned_w;
    logic [NUM_BANKS-1:0][SRC_W-1:0] brd_w, pend_w;

    assign bsel_w    = bus_addr / ADDR_W'(BANK_BYTES);
    assign boff_w    = 5'(bus_addr - bsel_w * ADDR_W'(BANK_BYTES));
    assign aligned_w = (boff_w[1:0] == 2'b00);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_w;
        assign hit_w = (bsel_w == ADDR_W'(b)) && aligned_w;

        intc_bank #(.SRC_W(SRC_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (src_i[b*SRC_W +: SRC_W]),
            .wr_i   (bus_wr && hit_w),
            .sel_i  (boff_w[4:2]),
            .wdata_i(bus_wdata),
            .rdata_o(brd_w[b]),
            .pend_o (pend_w[b])
        );

        intc_lowest #(.W(SRC_W)) u_low (
            .req_i(pend_w[b]),
            .idx_o(irq_idx_o[b*IDX_W +: IDX_W]),
            .any_o(irq_o[b])
        );

        // R4: the reported index names a pending source
        a_r4_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] |-> pend_w[b][irq_idx_o[b*IDX_W +: IDX_W]]);

        // R4: no pending source sits below the reported index
        a_r4_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[b] |-> ((pend_w[b] & ((SRC_W'(1) << irq_idx_o[b*IDX_W +: IDX_W]) - SRC_W'(1))) == '0));
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bsel_w == ADDR_W'(b) && aligned_w) bus_rdata = brd_w[b];
        end
    end
endmodule

// File: tb/test_intc_multibank.sv
module test_intc_multibank;
    localparam int PERIOD = 10;
    localparam int NB = 5;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NB*32-1:0] src = '1;
    logic [7:0]    addr = '0;
    logic          wr = 0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NB-1:0] irq;
    logic [NB*5-1:0] idx;
    int nvec = 0, nerr = 0;
    bit done = 0;

    intc_multibank i_intc_multibank (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq), .irq_idx_o(idx)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input int bank, input int off, input logic [31:0] d);
        addr = 8'(bank*24 + off);
        wdata = d;
        wr = 1;
        @(posedge clk);
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rd_reg(input int bank, input int off, output logic [31:0] d);
        addr = 8'(bank*24 + off);
        #1;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R2 irq after reset", 32'(irq), 32'h0);
        rd_reg(0, 4, v);  check("R2 enable reset", v, 0);
        rd_reg(2, 16, v); check("R2 polarity reset", v, 0);
        rd_reg(3, 20, v); check("R2 edge reset", v, 0);
        rd_reg(1, 0, v);  check("R2 status reset (inputs high, level low)", v, 0);
    endtask

    task automatic t_level_high;
        logic [31:0] v;
        src[3] = 0; tick(3);
        wr_reg(0, 16, 32'h8);
        wr_reg(0, 4, 32'h8);
        check("R5 idle irq", 32'(irq[0]), 0);
        src[3] = 1; tick(1);
        rd_reg(0, 0, v); check("R5 not yet after one edge", v, 0);
        tick(1);
        rd_reg(0, 0, v); check("R5 visible after two edges", v, 32'h8);
        check("R3 irq0 high", 32'(irq[0]), 1);
        check("R4 idx0", 32'(idx[4:0]), 3);
        wr_reg(0, 12, 32'h8);
        rd_reg(0, 0, v); check("R5 clear no effect while asserted", v, 32'h8);
        src[3] = 0; tick(2);
        check("R5 irq0 drops with input", 32'(irq[0]), 0);
    endtask

    task automatic t_level_low;
        wr_reg(1, 4, 32'h1);
        check("R6 inactive while high", 32'(irq[1]), 0);
        src[32] = 0; tick(2);
        check("R6 irq1 on low input", 32'(irq[1]), 1);
        check("R6 idx1", 32'(idx[9:5]), 0);
        check("R3 bank0 unaffected", 32'(irq[0]), 0);
        src[32] = 1; tick(2);
        check("R6 irq1 released", 32'(irq[1]), 0);
    endtask

    task automatic t_rising;
        logic [31:0] v;
        wr_reg(2, 16, 32'h80);
        wr_reg(2, 20, 32'h80);
        wr_reg(2, 4, 32'h80);
        src[71] = 0; tick(3);
        rd_reg(2, 0, v); check("R7 falling ignored", v, 0);
        src[71] = 1; tick(2);
        rd_reg(2, 0, v); check("R7 not yet after two edges", v, 0);
        tick(1);
        rd_reg(2, 0, v); check("R7 latched after three edges", v, 32'h80);
        check("R7 irq2 / idx2", {27'(irq[2]), idx[14:10]}, {27'd1, 5'd7});
        src[71] = 0; tick(3);
        rd_reg(2, 0, v); check("R7 stays latched", v, 32'h80);
        wr_reg(2, 12, 32'h0);
        rd_reg(2, 0, v); check("R9 zero clear no effect", v, 32'h80);
        wr_reg(2, 12, 32'h80);
        rd_reg(2, 0, v); check("R9 clear drops status", v, 0);
        check("R9 irq2 low", 32'(irq[2]), 0);
    endtask

    task automatic t_falling;
        logic [31:0] v;
        wr_reg(3, 20, 32'h8000_0000);
        wr_reg(3, 4, 32'h8000_0000);
        src[127] = 0; tick(3);
        rd_reg(3, 0, v); check("R8 falling latched", v, 32'h8000_0000);
        check("R8 idx3", 32'(idx[19:15]), 31);
        wr_reg(3, 12, 32'h8000_0000);
        src[127] = 1; tick(4);
        rd_reg(3, 0, v); check("R8 rising ignored", v, 0);
    endtask

    task automatic t_priority_map;
        logic [31:0] v;
        wr_reg(4, 4, 32'hFFFF_FFC0);
        wr_reg(4, 8, 32'h0000_0A50);
        rd_reg(4, 0, v); check("R10 set latches", v, 32'h0000_0A50);
        check("R4 lowest enabled", 32'(idx[24:20]), 6);
        wr_reg(4, 12, 32'h40);
        check("R4 next lowest", 32'(idx[24:20]), 9);
        wr_reg(4, 12, 32'hFFFF_FFFF);
        check("R3 irq4 low after clear", 32'(irq[4]), 0);
        wr_reg(4, 0, 32'hFFFF_FFFF);
        rd_reg(4, 0, v); check("R1 status write ignored", v, 0);
        rd_reg(4, 4, v); check("R1 enable readback", v, 32'hFFFF_FFC0);
        rd_reg(4, 8, v); check("R1 set reads 0", v, 0);
        rd_reg(4, 12, v); check("R1 clear reads 0", v, 0);
        addr = 8'h78; #1; check("R1 out of range reads 0", rdata, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick(4);
        t_reset();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_priority_map();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule